// File: doc/BRIEF.md
# Iterative Multiply/Divide Engine with HI/LO Result Pair

This block computes integer products and quotients over many clock cycles and keeps the outcome in two result registers, HI and LO. A start pulse, together with a 2-bit operation code and two operands, launches a multiply or a divide. Both operations come in signed and unsigned forms. A multiply works by shifting and adding, and a divide works by restoring subtraction. While the work is in flight, a busy flag lets the surrounding pipeline stall any instruction that wants to read HI or LO.

The outcome always goes to the same places. For a multiply, HI gets the upper half of the double-width product and LO gets the lower half. For a divide, LO gets the quotient and HI gets the remainder. Both registers are available at all times on two separate read ports, one per register. These ports serve the move-from-HI and move-from-LO instructions.

A divide with a zero divisor does not start any work. Instead the block raises an exception request for one cycle, carrying a fixed cause code, and leaves HI and LO as they were.

Top module: `muldiv_hilo_unit`

## Requirements
- R1: After reset, HI and LO read zero and both busy and the exception request are low.
- R2: A start seen while idle is accepted. The op field selects the operation: 2'b00 is a signed multiply, 2'b01 an unsigned multiply, 2'b10 a signed divide and 2'b11 an unsigned divide. Apart from the divide-by-zero case, busy is high for exactly W+1 cycles (33 by default), starting the cycle after the start edge.
- R3: A multiply writes the upper W bits of the 2W-bit product to HI and the lower W bits to LO. Operands are read as two's complement for op 2'b00 and as unsigned for op 2'b01.
- R4: An unsigned divide writes the quotient to LO and the remainder to HI.
- R5: A signed divide rounds the quotient toward zero, and the remainder takes the sign of the dividend. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R6: A divide whose divisor is zero raises the exception request for exactly one cycle, in the cycle after the start edge, with exc_code = 0x24. Busy stays low and HI and LO keep their values.
- R7: HI and LO do not change while busy is high. The new values appear on the same clock edge at which busy falls.
- R8: A start while busy is ignored. The running operation finishes on schedule with its own result, and no exception is raised.
- R9: Between operations, HI and LO hold their values on the read ports for as long as no new operation is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (accepted only while idle) |
| op | input | 2 | Operation select, encoded as in R2 |
| opa | input | W | Multiplicand or dividend |
| opb | input | W | Multiplier or divisor |
| busy | output | 1 | Operation in flight; reads of HI and LO must stall |
| hi_q | output | W | HI register read port |
| lo_q | output | W | LO register read port |
| exc_req | output | 1 | Divide-by-zero exception request (one-cycle pulse) |
| exc_code | output | 8 | Exception cause code while exc_req is high, zero otherwise |

## Verification
The start is applied at one clock edge, and busy is high from the cycle after that edge. The results are due on the edge W+1 cycles later, which is the edge at which busy falls. The bench drives its inputs on the falling clock edge and counts the busy cycles at each falling edge until busy drops. It compares HI and LO with the expected values in the first low-busy cycle, and while counting it checks that the old values are still held. A divide by zero is due one cycle after the start. For that case the bench samples the exception pulse, its code, a low busy and the unchanged HI and LO at the next falling edge, then checks one edge later that the pulse has gone.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [1:0] {
      OP_MUL_S = 2'b00,
      OP_MUL_U = 2'b01,
      OP_DIV_S = 2'b10,
      OP_DIV_U = 2'b11
   } md_op_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } md_state_e;

   function automatic logic op_is_div(input logic [1:0] o);
      return o[1];
   endfunction

   function automatic logic op_is_signed(input logic [1:0] o);
      return ~o[0];
   endfunction

endpackage

// File: rtl/muldiv_operand_prep.sv
module muldiv_operand_prep #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic         sgn,
   output logic [W-1:0] a_mag,
   output logic [W-1:0] b_mag,
   output logic         neg_ab,
   output logic         neg_a
);
   localparam int MSB = W - 1;

   logic a_neg, b_neg;

   assign a_neg  = sgn & a_in[MSB];
   assign b_neg  = sgn & b_in[MSB];
   assign a_mag  = a_neg ? (~a_in + 1'b1) : a_in;
   assign b_mag  = b_neg ? (~b_in + 1'b1) : b_in;
   assign neg_ab = a_neg ^ b_neg;
   assign neg_a  = a_neg;
endmodule

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
   parameter int W = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [W-1:0]   mplier,
   input  logic [W-1:0]   mcand_in,
   output logic [2*W-1:0] prod
);
   localparam int PW = 2 * W;

   logic [W-1:0]  mcand;
   logic [PW-1:0] acc;
   logic [W:0]    upper_sum;

   // add the multiplicand to the upper half when the current low bit is set
   assign upper_sum = {1'b0, acc[PW-1:W]} + (acc[0] ? {1'b0, mcand} : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mcand <= '0;
         acc   <= '0;
      end else if (load) begin
         mcand <= mcand_in;
         acc   <= {{W{1'b0}}, mplier};
      end else if (step) begin
         acc   <= {upper_sum, acc[W-1:1]};
      end
   end

   assign prod = acc;
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   logic [W-1:0] dvsr;
   logic [W-1:0] rem_r;
   logic [W-1:0] quo_r;
   logic [W:0]   shifted;
   logic [W:0]   trial;

   assign shifted = {rem_r, quo_r[W-1]};
   assign trial   = shifted - {1'b0, dvsr};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvsr  <= '0;
         rem_r <= '0;
         quo_r <= '0;
      end else if (load) begin
         dvsr  <= divisor;
         rem_r <= '0;
         quo_r <= dividend;
      end else if (step) begin
         if (!trial[W]) begin
            rem_r <= trial[W-1:0];
            quo_r <= {quo_r[W-2:0], 1'b1};
         end else begin
            // restore: keep the shifted partial remainder
            rem_r <= shifted[W-1:0];
            quo_r <= {quo_r[W-2:0], 1'b0};
         end
      end
   end

   assign quo = quo_r;
   assign rem = rem_r;
endmodule

// File: rtl/muldiv_hilo_unit.sv
module muldiv_hilo_unit
   import muldiv_pkg::*;
#(
   parameter int         W       = 32,
   parameter logic [7:0] DZ_CODE = 8'h24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic         busy,
   output logic [W-1:0] hi_q,
   output logic [W-1:0] lo_q,
   output logic         exc_req,
   output logic [7:0]   exc_code
);
   localparam int CW   = (W > 2) ? $clog2(W) : 1;
   localparam int LAST = W - 1;

   if (W < 4) begin : g_bad_width
      $error("muldiv_hilo_unit: W must be at least 4");
   end

   md_state_e    state;
   logic [CW-1:0] cnt;
   logic         accept, div_zero, go, stepping;
   logic         div_r, neg_ab_r, neg_a_r;
   logic         exc_r;

   logic [W-1:0]   a_mag, b_mag;
   logic           neg_ab, neg_a;
   logic [2*W-1:0] prod, prod_fix;
   logic [W-1:0]   quo, rem, quo_fix, rem_fix;

   assign accept   = start && (state == ST_IDLE);
   assign div_zero = accept && op_is_div(op) && (opb == '0);
   assign go       = accept && !div_zero;
   assign stepping = (state == ST_RUN);

   muldiv_operand_prep #(.W(W)) i_prep (
      .a_in   (opa),
      .b_in   (opb),
      .sgn    (op_is_signed(op)),
      .a_mag  (a_mag),
      .b_mag  (b_mag),
      .neg_ab (neg_ab),
      .neg_a  (neg_a)
   );

   muldiv_mul_core #(.W(W)) i_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go && !op_is_div(op)),
      .step     (stepping && !div_r),
      .mplier   (a_mag),
      .mcand_in (b_mag),
      .prod     (prod)
   );

   muldiv_div_core #(.W(W)) i_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go && op_is_div(op)),
      .step     (stepping && div_r),
      .dividend (a_mag),
      .divisor  (b_mag),
      .quo      (quo),
      .rem      (rem)
   );

   assign prod_fix = neg_ab_r ? (~prod + 1'b1) : prod;
   assign quo_fix  = neg_ab_r ? (~quo + 1'b1) : quo;
   assign rem_fix  = neg_a_r  ? (~rem + 1'b1) : rem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         div_r    <= 1'b0;
         neg_ab_r <= 1'b0;
         neg_a_r  <= 1'b0;
         exc_r    <= 1'b0;
         hi_q     <= '0;
         lo_q     <= '0;
      end else begin
         exc_r <= div_zero;
         unique case (state)
            ST_IDLE: begin
               if (go) begin
                  state    <= ST_RUN;
                  cnt      <= '0;
                  div_r    <= op_is_div(op);
                  neg_ab_r <= neg_ab;
                  neg_a_r  <= neg_a;
               end
            end
            ST_RUN: begin
               cnt <= cnt + 1'b1;
               if (cnt == CW'(LAST)) state <= ST_DONE;
            end
            ST_DONE: begin
               state <= ST_IDLE;
               if (div_r) begin
                  hi_q <= rem_fix;
                  lo_q <= quo_fix;
               end else begin
                  hi_q <= prod_fix[2*W-1:W];
                  lo_q <= prod_fix[W-1:0];
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign exc_req  = exc_r;
   assign exc_code = exc_r ? DZ_CODE : 8'h00;
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
   parameter int         W       = 32,
   parameter logic [7:0] DZ_CODE = 8'h24
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic [W-1:0] hi_q,
   input logic [W-1:0] lo_q,
   input logic         exc_req,
   input logic [7:0]   exc_code
);
   logic [15:0] run;

   always_ff @(posedge clk) begin
      if (!rst_n)    run <= '0;
      else if (busy) run <= run + 1'b1;
      else           run <= '0;
   end

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> run == 16'(W + 1)); // R2

   AST_HILO_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $stable(hi_q) && $stable(lo_q)); // R7

   AST_DZ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> !busy); // R6

   AST_DZ_KEEPS_HILO: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> $stable(hi_q) && $stable(lo_q)); // R6

   AST_DZ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> exc_code == DZ_CODE); // R6

   AST_DZ_FROM_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req |-> $past(start) && !$past(busy)); // R8

   AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start)); // R8
endmodule

bind muldiv_hilo_unit muldiv_hilo_chk #(.W(W), .DZ_CODE(DZ_CODE)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .busy     (busy),
   .hi_q     (hi_q),
   .lo_q     (lo_q),
   .exc_req  (exc_req),
   .exc_code (exc_code)
);

// File: tb/test_muldiv_hilo_unit.sv
module test_muldiv_hilo_unit;
   localparam time HALF = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        busy;
   logic [31:0] hi_q, lo_q;
   logic        exc_req;
   logic [7:0]  exc_code;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #HALF clk = ~clk;

   muldiv_hilo_unit i_muldiv_hilo_unit (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .busy(busy), .hi_q(hi_q), .lo_q(lo_q), .exc_req(exc_req), .exc_code(exc_code)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // expected {HI,LO}
   function automatic logic [63:0] model(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
      longint sa, sb, q, r;
      logic [63:0] ua, ub;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = {32'h0, a};
      ub = {32'h0, b};
      case (o)
         2'b00: return 64'(sa * sb);
         2'b01: return ua * ub;
         2'b10: begin
            q = sa / sb;
            r = sa % sb;
            return {r[31:0], q[31:0]};
         end
         default: return {a % b, a / b};
      endcase
   endfunction

   task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b,
                         input bit intrude, input string req);
      logic [63:0] exp;
      logic [31:0] old_hi, old_lo;
      int n;
      bit held, noexc;
      exp    = model(o, a, b);
      old_hi = hi_q;
      old_lo = lo_q;
      start = 1'b1; op = o; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0;
      n = 0; held = 1; noexc = 1;
      while (busy && n < 100) begin
         if (hi_q !== old_hi || lo_q !== old_lo) held = 0;
         if (exc_req) noexc = 0;
         start = intrude && (n == 10);
         if (start) begin
            op = 2'b11; opa = 32'h55; opb = 32'h0;
         end
         n++;
         @(negedge clk);
      end
      start = 1'b0;
      check(n == 33, "R2 busy cycle count", 64'(n), 64'd33);
      check(held, "R7 HI/LO frozen while busy", {old_hi, old_lo}, {old_hi, old_lo});
      check({hi_q, lo_q} === exp, req, {hi_q, lo_q}, exp);
      if (intrude) check(noexc, "R8 start while busy ignored, no exception", 64'(noexc), 64'd1);
   endtask

   task automatic div_zero(input logic [1:0] o, input logic [31:0] a);
      logic [31:0] old_hi, old_lo;
      old_hi = hi_q;
      old_lo = lo_q;
      start = 1'b1; op = o; opa = a; opb = 32'h0;
      @(negedge clk);
      start = 1'b0;
      check(exc_req === 1'b1, "R6 exception request raised", 64'(exc_req), 64'd1);
      check(exc_code === 8'h24, "R6 exception code", 64'(exc_code), 64'h24);
      check(busy === 1'b0, "R6 busy stays low", 64'(busy), 64'd0);
      check({hi_q, lo_q} === {old_hi, old_lo}, "R6 HI/LO kept", {hi_q, lo_q}, {old_hi, old_lo});
      @(negedge clk);
      check(exc_req === 1'b0 && busy === 1'b0, "R6 request lasts one cycle",
            {62'd0, exc_req, busy}, 64'd0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(hi_q === 32'h0 && lo_q === 32'h0, "R1 HI/LO reset", {hi_q, lo_q}, 64'h0);
      check(busy === 1'b0, "R1 busy reset", 64'(busy), 64'd0);
      check(exc_req === 1'b0 && exc_code === 8'h0, "R1 exception reset", {55'd0, exc_req, exc_code}, 64'd0);

      // R3 multiplies
      run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 unsigned mul max");
      run_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R3 signed mul -1*-1");
      run_op(2'b00, 32'h8000_0000, 32'h8000_0000, 0, "R3 signed mul min*min");
      run_op(2'b00, 32'hFFFF_FFFD, 32'd7, 0, "R3 signed mul -3*7");
      run_op(2'b01, 32'h0, 32'h1234_5678, 0, "R3 unsigned mul by zero");
      // R4 unsigned divides
      run_op(2'b11, 32'd100, 32'd7, 0, "R4 unsigned div 100/7");
      run_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R4 unsigned div big/max");
      run_op(2'b11, 32'd5, 32'd9, 0, "R4 unsigned div small/large");
      // R5 signed divides
      run_op(2'b10, 32'hFFFF_FFF9, 32'd2, 0, "R5 signed div -7/2");
      run_op(2'b10, 32'd7, 32'hFFFF_FFFE, 0, "R5 signed div 7/-2");
      run_op(2'b10, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, "R5 signed div -7/-2");
      run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF, 0, "R5 signed div min/-1");
      // R6 divide by zero, HI/LO set to a known pair first
      run_op(2'b01, 32'h0001_0003, 32'h0002_0005, 0, "R3 mul before div-by-zero");
      div_zero(2'b10, 32'h1234_5678);
      div_zero(2'b11, 32'hFFFF_FFFF);
      // R8 start while busy
      run_op(2'b10, 32'hFFFF_FF00, 32'd3, 1, "R8 first op result kept");
      run_op(2'b00, 32'h7FFF_FFFF, 32'h8000_0001, 1, "R8 mul with intruding start");
      // R9 read ports hold
      begin
         logic [31:0] h0, l0;
         bit same;
         h0 = hi_q; l0 = lo_q; same = 1;
         repeat (8) begin
            @(negedge clk);
            if (hi_q !== h0 || lo_q !== l0) same = 0;
         end
         check(same, "R9 HI/LO held while idle", {hi_q, lo_q}, {h0, l0});
      end
      // random mix
      for (int k = 0; k < 60; k++) begin
         logic [1:0]  ro;
         logic [31:0] ra, rb;
         ro = 2'($urandom_range(3));
         ra = $urandom;
         rb = $urandom;
         if (k % 4 == 0) rb = rb >> ($urandom_range(31));
         if (rb == 32'h0) rb = 32'h1;
         run_op(ro, ra, rb, (k % 7 == 3),
                ro[1] ? (ro[0] ? "R4 random unsigned div" : "R5 random signed div") : "R3 random mul");
      end
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(2 * HALF * 200000);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule